// File: doc/BRIEF.md
# MSI-X vector table controller

This block keeps a memory-mapped table of message-signalled interrupt vectors, plus a pending-bit word, behind a 32-bit register bus. Device logic raises interrupt requests one vector at a time on a valid/ready input. For each accepted request the block does one of three things. It drops the request, or it records the request as pending because the vector is masked, or it emits one message write (a 64-bit address and 32-bit data taken from the vector's entry) on a request/acknowledge master port.

Masking works at two levels. Each vector has its own mask bit. The whole function is also masked whenever the enable input is low or the mask-all input is high. A message deferred by a mask is replayed automatically once the vector becomes unmasked. A table write that clears a vector's mask bit replays that vector at once. A change on either control input starts a serial rescan that replays every pending, now-unmasked vector in ascending order.

Back-pressure on the request input works as follows. `irq_ready` is low while a rescan is running or owed, while a message is waiting for its acknowledge, in the cycle a control input changes, and in any cycle with a register write. A request is taken on a clock edge where `irq_valid` and `irq_ready` are both high. On the message port, `msg_req` rises with its address and data and holds them until the edge where `msg_ack` is sampled high. A new message can start at the earliest in the cycle after that edge.

Top module: `msix_vector_ctrl`

## Requirements
- R1: After reset, every vector's control word reads 1, every address and data word reads 0, the pending word reads 0, and `msg_req` and `busy` are low.
- R2: Entry v occupies byte offsets 16v to 16v+15 of a 4 KiB window: address bits 31:0 at +0, address bits 63:32 at +4, message data at +8, and a control word at +12 whose bit 0 is the vector mask and whose other bits read 0. Address bits 1:0 are ignored.
- R3: A write whose offset divided by 16 is NUM_VEC or more is discarded, so the pending word is read-only. Reads of table offsets at or beyond entry NUM_VEC return 0.
- R4: The pending bit of vector v reads back at offset 0x800, bit v (byte v/8, bit v mod 8). Later pending words read 0.
- R5: The function mask is (not enable) or mask-all. A vector is masked when the function mask or its own mask bit is set.
- R6: A request for a vector number of NUM_VEC or more, or for a vector whose in-use input is low, is consumed and has no effect.
- R7: A request for a masked, in-use vector sets its pending bit and sends no message.
- R8: A request for an unmasked, in-use vector sends exactly one message, carrying the entry's 64-bit address and data.
- R9: While `msg_req` is high and `msg_ack` is low, `msg_req`, `msg_addr` and `msg_data` stay unchanged.
- R10: A control-word write that clears the mask of a pending vector while the function mask is clear clears that pending bit and sends that vector's message.
- R11: A change of the enable or mask-all input raises `busy` and scans vectors 0 to NUM_VEC-1. Each pending vector that is now unmasked has its pending bit cleared and its message sent, in ascending vector order.
- R12: `irq_ready` is low while `busy` is high, while a message is outstanding, in the cycle a control input changes, and during a register write.
- R13: When a vector's in-use input falls, its pending bit clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte offset within the 4 KiB window |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ctl_enable | input | 1 | Enable for message interrupts |
| ctl_mask_all | input | 1 | Function-wide mask |
| vec_in_use | input | NUM_VEC | Per-vector in-use flags |
| irq_valid | input | 1 | Interrupt request valid |
| irq_ready | output | 1 | Interrupt request accepted when high with valid |
| irq_vec | input | 5 | Requested vector number |
| msg_req | output | 1 | Message write request |
| msg_ack | input | 1 | Message write acknowledge |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| busy | output | 1 | Rescan running or owed |

## Verification
A pending bit left set on an unmasked vector shows up as a message that never comes. The bench catches it when it compares the message list and reads back the pending word after each operation settles, at most NUM_VEC plus a few cycles after the triggering write or control change. A wrong mask or wrong scan order shows up as a missing, extra or reordered message in the same comparison. A corrupt entry shows up as a wrong address or data word in that comparison and in direct read-back.

// File: rtl/msix_pkg.sv
package msix_pkg;
  localparam int MSIX_MAX_VEC = 32;
  localparam int MSIX_VEC_W   = 5;

  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_SCAN = 1'b1
  } eng_state_e;

  function automatic logic fn_func_mask(input logic en, input logic mask_all);
    return !en || mask_all;
  endfunction
endpackage

// File: rtl/msix_table.sv
module msix_table #(
  parameter int NUM_VEC = 8,
  parameter int IW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [9:0]         word_addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic [NUM_VEC-1:0] vmask,
  input  logic [IW-1:0]      sel_idx,
  output logic [63:0]        sel_addr,
  output logic [31:0]        sel_data,
  output logic               wr_clr,
  output logic [IW-1:0]      wr_vec
);
  logic [31:0] lo_q  [NUM_VEC];
  logic [31:0] hi_q  [NUM_VEC];
  logic [31:0] dat_q [NUM_VEC];
  logic [NUM_VEC-1:0] msk_q;

  logic [7:0]    ent_idx;
  logic [1:0]    wsel;
  logic          ent_ok;
  logic [IW-1:0] ri;

  assign ent_idx = word_addr[9:2];
  assign wsel    = word_addr[1:0];
  assign ent_ok  = (int'(ent_idx) < NUM_VEC);
  assign ri      = ent_idx[IW-1:0];

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[g]  <= '0;
        hi_q[g]  <= '0;
        dat_q[g] <= '0;
        msk_q[g] <= 1'b1;
      end else if (wr_en && (int'(ent_idx) == g)) begin
        case (wsel)
          2'd0:    lo_q[g]  <= wdata;
          2'd1:    hi_q[g]  <= wdata;
          2'd2:    dat_q[g] <= wdata;
          default: msk_q[g] <= wdata[0];
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (ent_ok) begin
      case (wsel)
        2'd0:    rdata = lo_q[ri];
        2'd1:    rdata = hi_q[ri];
        2'd2:    rdata = dat_q[ri];
        default: rdata = {31'b0, msk_q[ri]};
      endcase
    end
  end

  assign vmask    = msk_q;
  assign sel_addr = {hi_q[sel_idx], lo_q[sel_idx]};
  assign sel_data = dat_q[sel_idx];
  assign wr_vec   = ri;
  assign wr_clr   = wr_en && ent_ok && (wsel == 2'd3) && msk_q[ri] && !wdata[0];
endmodule

// File: rtl/msix_pend.sv
module msix_pend #(
  parameter int NUM_VEC = 8,
  parameter int IW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [IW-1:0]      set_idx,
  input  logic               clr_en,
  input  logic [IW-1:0]      clr_idx,
  input  logic [NUM_VEC-1:0] inuse,
  output logic [NUM_VEC-1:0] pend
);
  logic [NUM_VEC-1:0] pend_q;
  logic [NUM_VEC-1:0] inuse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inuse_q <= '0;
    else        inuse_q <= inuse;
  end

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[g] <= 1'b0;
      end else if ((clr_en && (int'(clr_idx) == g)) || (inuse_q[g] && !inuse[g])) begin
        pend_q[g] <= 1'b0;
      end else if (set_en && (int'(set_idx) == g)) begin
        pend_q[g] <= 1'b1;
      end
    end
  end

  assign pend = pend_q;

  AST_PEND_NEEDS_USE: assert property (@(posedge clk) disable iff (!rst_n) (pend_q & ~inuse_q) == '0); // R13
endmodule

// File: rtl/msix_engine.sv
module msix_engine
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int IW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctl_en,
  input  logic                  ctl_mall,
  input  logic                  irq_valid,
  input  logic [MSIX_VEC_W-1:0] irq_vec,
  output logic                  irq_ready,
  input  logic                  bus_wr,
  input  logic                  wr_clr,
  input  logic [IW-1:0]         wr_vec,
  input  logic [NUM_VEC-1:0]    vmask,
  input  logic [NUM_VEC-1:0]    pend,
  input  logic [NUM_VEC-1:0]    inuse,
  output logic [IW-1:0]         sel_idx,
  input  logic [63:0]           sel_addr,
  input  logic [31:0]           sel_data,
  output logic                  pset_en,
  output logic [IW-1:0]         pset_idx,
  output logic                  pclr_en,
  output logic [IW-1:0]         pclr_idx,
  output logic                  msg_req,
  input  logic                  msg_ack,
  output logic [63:0]           msg_addr,
  output logic [31:0]           msg_data,
  output logic                  busy
);
  localparam logic [IW-1:0] LAST = IW'(NUM_VEC - 1);

  eng_state_e         state_q;
  logic [IW-1:0]      ptr_q;
  logic               rescan_q;
  logic [1:0]         ctl_q;
  logic               fmask;
  logic [NUM_VEC-1:0] masked;
  logic               ctl_chg;
  logic               idle;
  logic [IW-1:0]      iv;
  logic               irq_take;
  logic               irq_ok;
  logic               direct;
  logic               direct_go;
  logic               direct_defer;
  logic               scan_hit;
  logic               irq_send;
  logic               issue;

  assign fmask   = fn_func_mask(ctl_en, ctl_mall);
  assign masked  = vmask | {NUM_VEC{fmask}};
  assign ctl_chg = ({ctl_en, ctl_mall} != ctl_q);
  assign idle    = (state_q == ENG_IDLE) && !rescan_q && !msg_req && !ctl_chg;

  assign irq_ready = idle && !bus_wr;
  assign iv        = irq_vec[IW-1:0];
  assign irq_take  = irq_valid && irq_ready;
  assign irq_ok    = (int'(irq_vec) < NUM_VEC) && inuse[iv];
  assign irq_send  = irq_take && irq_ok && !masked[iv];

  assign direct       = wr_clr && pend[wr_vec] && !fmask;
  assign direct_go    = direct && idle;
  assign direct_defer = direct && !idle;

  assign scan_hit = (state_q == ENG_SCAN) && !msg_req && pend[ptr_q] && !masked[ptr_q];
  assign issue    = scan_hit || direct_go || irq_send;

  always_comb begin
    if (state_q == ENG_SCAN) sel_idx = ptr_q;
    else if (bus_wr)         sel_idx = wr_vec;
    else                     sel_idx = iv;
  end

  assign pset_en  = irq_take && irq_ok && masked[iv];
  assign pset_idx = iv;
  assign pclr_en  = scan_hit || direct_go;
  assign pclr_idx = (state_q == ENG_SCAN) ? ptr_q : wr_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ENG_IDLE;
      ptr_q    <= '0;
      rescan_q <= 1'b0;
      ctl_q    <= 2'b00;
      msg_req  <= 1'b0;
      msg_addr <= '0;
      msg_data <= '0;
    end else begin
      ctl_q <= {ctl_en, ctl_mall};
      if (ctl_chg) begin
        state_q <= ENG_SCAN;
        ptr_q   <= '0;
      end else if (state_q == ENG_SCAN) begin
        if (!msg_req) begin
          if (ptr_q == LAST) begin
            if (rescan_q) begin
              ptr_q    <= '0;
              rescan_q <= 1'b0;
            end else begin
              state_q <= ENG_IDLE;
            end
          end else begin
            ptr_q <= ptr_q + 1'b1;
          end
        end
      end else if (rescan_q && !msg_req) begin
        state_q  <= ENG_SCAN;
        ptr_q    <= '0;
        rescan_q <= 1'b0;
      end
      if (direct_defer) rescan_q <= 1'b1;

      if (issue) begin
        msg_req  <= 1'b1;
        msg_addr <= sel_addr;
        msg_data <= sel_data;
      end else if (msg_ack) begin
        msg_req <= 1'b0;
      end
    end
  end

  assign busy = (state_q == ENG_SCAN) || rescan_q;

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (msg_req && !msg_ack) |=> (msg_req && $stable(msg_addr) && $stable(msg_data))); // R9
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n) irq_ready |-> (!busy && !msg_req && !bus_wr)); // R12
  AST_NO_STRANDED_PEND: assert property (@(posedge clk) disable iff (!rst_n) ((state_q == ENG_IDLE) && !rescan_q && !ctl_chg) |-> ((pend & ~masked) == '0)); // R11
  AST_SCAN_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ENG_SCAN) |-> (int'(ptr_q) < NUM_VEC)); // R11
  AST_MASKED_NO_SEND: assert property (@(posedge clk) disable iff (!rst_n) pset_en |-> !issue); // R7
endmodule

// File: rtl/msix_vector_ctrl.sv
module msix_vector_ctrl
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [11:0]           bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic                  ctl_enable,
  input  logic                  ctl_mask_all,
  input  logic [NUM_VEC-1:0]    vec_in_use,
  input  logic                  irq_valid,
  output logic                  irq_ready,
  input  logic [MSIX_VEC_W-1:0] irq_vec,
  output logic                  msg_req,
  input  logic                  msg_ack,
  output logic [63:0]           msg_addr,
  output logic [31:0]           msg_data,
  output logic                  busy
);
  localparam int IW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  logic               unused_addr_lsb;
  logic [31:0]        tbl_rdata;
  logic [31:0]        pend_word;
  logic [NUM_VEC-1:0] vmask;
  logic [NUM_VEC-1:0] pend;
  logic [IW-1:0]      sel_idx;
  logic [63:0]        sel_addr;
  logic [31:0]        sel_data;
  logic               wr_clr;
  logic [IW-1:0]      wr_vec;
  logic               pset_en;
  logic [IW-1:0]      pset_idx;
  logic               pclr_en;
  logic [IW-1:0]      pclr_idx;
  logic               tbl_wr;

  assign unused_addr_lsb = ^bus_addr[1:0];
  assign tbl_wr = bus_wr && !bus_addr[11];

  msix_table #(.NUM_VEC(NUM_VEC), .IW(IW)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (tbl_wr),
    .word_addr (bus_addr[11:2]),
    .wdata     (bus_wdata),
    .rdata     (tbl_rdata),
    .vmask     (vmask),
    .sel_idx   (sel_idx),
    .sel_addr  (sel_addr),
    .sel_data  (sel_data),
    .wr_clr    (wr_clr),
    .wr_vec    (wr_vec)
  );

  msix_pend #(.NUM_VEC(NUM_VEC), .IW(IW)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (pset_en),
    .set_idx (pset_idx),
    .clr_en  (pclr_en),
    .clr_idx (pclr_idx),
    .inuse   (vec_in_use),
    .pend    (pend)
  );

  msix_engine #(.NUM_VEC(NUM_VEC), .IW(IW)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_en    (ctl_enable),
    .ctl_mall  (ctl_mask_all),
    .irq_valid (irq_valid),
    .irq_vec   (irq_vec),
    .irq_ready (irq_ready),
    .bus_wr    (bus_wr),
    .wr_clr    (wr_clr),
    .wr_vec    (wr_vec),
    .vmask     (vmask),
    .pend      (pend),
    .inuse     (vec_in_use),
    .sel_idx   (sel_idx),
    .sel_addr  (sel_addr),
    .sel_data  (sel_data),
    .pset_en   (pset_en),
    .pset_idx  (pset_idx),
    .pclr_en   (pclr_en),
    .pclr_idx  (pclr_idx),
    .msg_req   (msg_req),
    .msg_ack   (msg_ack),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data),
    .busy      (busy)
  );

  always_comb begin
    pend_word = '0;
    pend_word[NUM_VEC-1:0] = pend;
  end

  always_comb begin
    if (bus_addr[11]) bus_rdata = (bus_addr[10:2] == '0) ? pend_word : '0;
    else              bus_rdata = tbl_rdata;
  end

  AST_PEND_RO: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr && bus_addr[11]) |=> $stable(vmask)); // R3
endmodule

// File: tb/test_msix_vector_ctrl.sv
module test_msix_vector_ctrl;
  localparam int N = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          ctl_enable = 1'b0;
  logic          ctl_mask_all = 1'b0;
  logic [N-1:0]  vec_in_use = '1;
  logic          irq_valid = 1'b0;
  logic          irq_ready;
  logic [4:0]    irq_vec = '0;
  logic          msg_req;
  logic          msg_ack = 1'b0;
  logic [63:0]   msg_addr;
  logic [31:0]   msg_data;
  logic          busy;

  int total = 0;
  int bad = 0;

  logic [31:0] m_lo [N];
  logic [31:0] m_hi [N];
  logic [31:0] m_dat[N];
  logic [N-1:0] m_msk;
  logic [31:0]  m_pend;
  logic         m_en, m_ma;
  logic [95:0]  exp_q[$];
  logic [95:0]  got_q[$];
  logic         hold_v;
  logic [95:0]  hold_val;

  always #4 clk = ~clk;

  msix_vector_ctrl #(.NUM_VEC(N)) i_msix_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctl_enable(ctl_enable),
    .ctl_mask_all(ctl_mask_all), .vec_in_use(vec_in_use), .irq_valid(irq_valid),
    .irq_ready(irq_ready), .irq_vec(irq_vec), .msg_req(msg_req), .msg_ack(msg_ack),
    .msg_addr(msg_addr), .msg_data(msg_data), .busy(busy)
  );

  task automatic chk(input bit ok, input string rq, input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic m_fm();
    return !m_en || m_ma;
  endfunction

  function automatic logic [95:0] ent(input int v);
    return {m_hi[v], m_lo[v], m_dat[v]};
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    int v = int'(a[11:4]);
    if (a[11]) return (a[10:2] == '0) ? m_pend : 32'h0;
    if (v >= N) return 32'h0;
    case (a[3:2])
      2'd0:    return m_lo[v];
      2'd1:    return m_hi[v];
      2'd2:    return m_dat[v];
      default: return {31'b0, m_msk[v]};
    endcase
  endfunction

  // message port: random acknowledge, stability check while waiting (R9)
  initial begin
    hold_v = 1'b0;
    hold_val = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        msg_ack = 1'b0;
        hold_v = 1'b0;
      end else if (msg_ack) begin
        msg_ack = 1'b0;
        hold_v = 1'b0;
      end else if (msg_req) begin
        if (hold_v) chk({msg_addr, msg_data} == hold_val, "R9 hold", {msg_addr, msg_data}, hold_val);
        hold_v = 1'b1;
        hold_val = {msg_addr, msg_data};
        if ($urandom % 3 == 0) begin
          msg_ack = 1'b1;
          got_q.push_back({msg_addr, msg_data});
        end
      end
    end
  end

  task automatic settle();
    int q = 0;
    while (q < 4) begin
      @(negedge clk);
      if (!busy && !msg_req && !msg_ack) q++;
      else q = 0;
    end
  endtask

  task automatic check_msgs(input string rq);
    chk(got_q.size() == exp_q.size(), rq, 96'(got_q.size()), 96'(exp_q.size()));
    while (got_q.size() > 0 && exp_q.size() > 0) begin
      logic [95:0] g = got_q.pop_front();
      logic [95:0] e = exp_q.pop_front();
      chk(g == e, rq, g, e);
    end
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic bwr(input logic [11:0] a, input logic [31:0] d);
    int v = int'(a[11:4]);
    @(negedge clk);
    bus_wr = 1'b1;
    bus_addr = a;
    bus_wdata = d;
    if (!a[11] && v < N) begin
      case (a[3:2])
        2'd0: m_lo[v] = d;
        2'd1: m_hi[v] = d;
        2'd2: m_dat[v] = d;
        default: begin
          logic was = m_fm() || m_msk[v];
          m_msk[v] = d[0];
          if (was && !(m_fm() || m_msk[v]) && m_pend[v]) begin
            m_pend[v] = 1'b0;
            exp_q.push_back(ent(v));
          end
        end
      endcase
    end
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic brd_chk(input logic [11:0] a, input string rq);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(bus_rdata == m_read(a), rq, 96'(bus_rdata), 96'(m_read(a)));
  endtask

  task automatic m_ctl(input logic e, input logic m);
    if (e == m_en && m == m_ma) return;
    m_en = e;
    m_ma = m;
    for (int v = 0; v < N; v++) begin
      if (m_pend[v] && !(m_fm() || m_msk[v])) begin
        m_pend[v] = 1'b0;
        exp_q.push_back(ent(v));
      end
    end
  endtask

  task automatic m_irq(input int v);
    if (v < N && vec_in_use[v]) begin
      if (m_fm() || m_msk[v]) m_pend[v] = 1'b1;
      else exp_q.push_back(ent(v));
    end
  endtask

  // irq_valid must already be high with irq_vec set, at a negedge
  task automatic irq_wait(input int v);
    forever begin
      #1;
      if (irq_ready) break;
      @(negedge clk);
    end
    m_irq(v);
    @(negedge clk);
    irq_valid = 1'b0;
  endtask

  task automatic do_irq(input int v);
    @(negedge clk);
    irq_valid = 1'b1;
    irq_vec = 5'(v);
    irq_wait(v);
  endtask

  task automatic do_ctl(input logic e, input logic m);
    @(negedge clk);
    ctl_enable = e;
    ctl_mask_all = m;
    m_ctl(e, m);
  endtask

  task automatic do_use(input logic [N-1:0] u);
    @(negedge clk);
    vec_in_use = u;
    for (int v = 0; v < N; v++) if (!u[v]) m_pend[v] = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int v = 0; v < N; v++) begin
      m_lo[v] = '0; m_hi[v] = '0; m_dat[v] = '0;
    end
    m_msk = '1; m_pend = '0; m_en = 1'b0; m_ma = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!msg_req && !busy, "R1 outputs", {94'b0, msg_req, busy}, 96'b0);
    for (int v = 0; v < N; v++) begin
      brd_chk(12'(16 * v + 12), "R1 mask");
      brd_chk(12'(16 * v), "R1 addr");
    end
    brd_chk(12'h800, "R1 pending");

    // R2 programming, with low address bits ignored
    for (int v = 0; v < N; v++) begin
      bwr(12'(16 * v + 1), 32'h1000_0000 + 32'(v * 16));
      bwr(12'(16 * v + 4 + 2), 32'hF000_0000 | 32'(v));
      bwr(12'(16 * v + 8 + 3), 32'hDA7A_0000 + 32'(v));
    end
    for (int v = 0; v < N; v++) begin
      brd_chk(12'(16 * v), "R2 lo");
      brd_chk(12'(16 * v + 5), "R2 hi");
      brd_chk(12'(16 * v + 8), "R2 data");
    end
    bwr(12'(16 * 3 + 12), 32'hFFFF_FFFE);
    brd_chk(12'(16 * 3 + 12), "R2 ctrl bits");
    bwr(12'(16 * 3 + 12), 32'h1);

    // R3 out-of-range and pending-window writes are dropped
    bwr(12'(16 * N), 32'hBAD0_0001);
    bwr(12'h800, 32'hFFFF_FFFF);
    brd_chk(12'(16 * N), "R3 beyond table");
    brd_chk(12'h800, "R3 pending read-only");

    // R7/R5 disabled function masks everything
    do_irq(2);
    do_irq(4);
    settle();
    check_msgs("R7 masked no message");
    brd_chk(12'h800, "R4 pending bits 2,4");
    brd_chk(12'h804, "R4 later word zero");

    // R5 enabling leaves per-vector masks in force
    do_ctl(1'b1, 1'b0);
    settle();
    check_msgs("R5 vector masks hold");

    // R10 unmask pending vector 2
    bwr(12'(16 * 2 + 12), 32'h0);
    settle();
    check_msgs("R10 replay on unmask");
    brd_chk(12'h800, "R10 pending cleared");

    // R8 direct send; R6 drops
    do_irq(2);
    settle();
    check_msgs("R8 direct message");
    do_irq(N);
    do_irq(N + 5);
    do_use(~8'(1 << 2));
    do_irq(2);
    settle();
    check_msgs("R6 dropped requests");
    do_use('1);

    // R11/R12 scan in ascending order, request held off
    do_ctl(1'b1, 1'b1);
    bwr(12'(16 * 5 + 12), 32'h0);
    bwr(12'(16 * 1 + 12), 32'h0);
    bwr(12'(16 * 3 + 12), 32'h0);
    do_irq(5);
    do_irq(3);
    do_irq(1);
    settle();
    check_msgs("R5 mask-all defers");
    @(negedge clk);
    ctl_mask_all = 1'b0;
    irq_valid = 1'b1;
    irq_vec = 5'd2;
    m_ctl(1'b1, 1'b0);
    #1;
    chk(!irq_ready, "R12 ready low on control change", 96'(irq_ready), 96'd0);
    @(negedge clk);
    chk(busy, "R11 busy during scan", 96'(busy), 96'd1);
    chk(!irq_ready, "R12 ready low while busy", 96'(irq_ready), 96'd0);
    irq_wait(2);
    settle();
    check_msgs("R11 scan order then request");

    // R13 in-use drop clears pending
    bwr(12'(16 * 6 + 12), 32'h1);
    do_irq(6);
    settle();
    brd_chk(12'h800, "R7 pending 6");
    do_use(~8'(1 << 6));
    settle();
    brd_chk(12'h800, "R13 pending cleared");
    do_use('1);
    check_msgs("R13 no message");

    // random phase
    for (int it = 0; it < 300; it++) begin
      int op = int'($urandom % 10);
      if (op < 3) begin
        int v = int'($urandom % (N + 2));
        int w = int'($urandom % 4);
        bwr(12'(16 * v + 4 * w), (w == 3) ? 32'($urandom % 2) : $urandom);
      end else if (op < 7) begin
        do_irq(int'($urandom % (N + 2)));
      end else if (op < 9) begin
        do_ctl(1'($urandom), 1'($urandom));
      end else begin
        do_use(N'($urandom) | N'($urandom));
      end
      settle();
      check_msgs("R8 R10 R11 random messages");
      brd_chk(12'h800, "R4 R13 random pending");
      brd_chk(12'($urandom % 12'h200), "R2 random read");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule